// File: doc/BRIEF.md
# Serial Register Access Slave with Address Auto-Increment

This block is a synchronous serial slave. It gives a host controller read and write access to a 256-location byte-wide register space. A host frame begins when the active-low select falls and ends when it rises. Each frame carries one address byte and then any number of data bytes, with every byte shifted least significant bit first. The direction pin chooses the kind of frame: low writes and high reads. An internal counter steps through consecutive locations. When its low nibble passes 0xF it wraps to 0 and leaves the upper nibble as it was. To reach a location that does not follow on, the host must close the frame and open a new one.

SCLK, select, data-in and direction are first synchronized into the system clock, and all logic then runs in that one domain. A write frame issues one register-file write per completed data byte. A read frame starts a fetch as soon as the address byte is complete. The fetched byte is shifted out on SDO on falling SCLK edges, and the next location is fetched at the end of each data byte. WAIT is raised for a fixed number of system clocks after the address byte, which covers the prefetch. It never appears between data bytes.

Top module: `serial_reg_port`

## Requirements
- R1: After reset, wait_o, sdo_o, sdo_oe_o, rf_we_o and rf_re_o are all low.
- R2: In a write frame, each completed data byte (first received bit in bit 0) is written once to the current counter address, and the counter then advances by one.
- R3: When the counter advances, bits [3:0] go from 0xF to 0x0 and bits [7:4] stay unchanged. For example, 0x3F is followed by 0x30.
- R4: In a read frame, data byte k returns the contents of the address byte advanced k times. Bit 0 is on SDO before the first data rising edge, and each later bit follows a falling SCLK edge.
- R5: During read data bytes, SDI is ignored: no register-file write occurs and the returned data is not affected.
- R6: wait_o rises after the address byte completes and falls within WAIT_CYC+1 system clocks. It is never high after a data byte.
- R7: Raising cs_ni discards a partly received byte without any write. The next frame starts again with an address byte.
- R8: sdo_oe_o and sdo_o are low while cs_ni is high and throughout write frames.
- R9: Direction is taken when the address byte completes. A change on dir_i later in the frame has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Host serial clock |
| cs_ni | input | 1 | Frame select, active low |
| sdi_i | input | 1 | Serial data from the host |
| dir_i | input | 1 | Direction: 0 write, 1 read |
| sdo_o | output | 1 | Serial data to the host, low when not driven |
| sdo_oe_o | output | 1 | Output enable for sdo_o |
| wait_o | output | 1 | Host must hold off the first data byte while high |
| rf_we_o | output | 1 | Register-file write strobe, one cycle |
| rf_re_o | output | 1 | Register-file read strobe, one cycle |
| rf_addr_o | output | 8 | Register-file address |
| rf_wdata_o | output | 8 | Register-file write data |
| rf_rdata_i | input | 8 | Register-file read data, valid one cycle after rf_re_o |

## Verification
The assertions depend on the host holding each SCLK level for several system clocks, so that every edge is seen once after synchronization. They also depend on the host leaving enough time after a data byte for the next fetch to load before the following falling edge. The bench therefore holds each SCLK phase for eight system clocks and leaves at least a dozen clocks between bytes. After the address byte it waits twenty clocks, which is longer than WAIT lasts. Select and direction are changed only while SCLK is high, with one exception: the abort case deliberately raises select in the middle of a byte.

// File: rtl/srp_pkg.sv
package srp_pkg;
  typedef enum logic {PH_ADDR, PH_DATA} phase_e;
endpackage

// File: rtl/srp_sync.sv
module srp_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= RST_VAL;
      else         stg_q[s] <= (s == 0) ? d_i : stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/srp_rx.sv
module srp_rx #(
  parameter int BW = 8,
  localparam int CW = $clog2(BW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          shift_i,
  input  logic          bit_i,
  output logic [BW-1:0] byte_o,
  output logic          done_o,
  output logic [CW-1:0] cnt_o
);
  logic [BW-1:0] sh_q;
  logic [CW-1:0] cnt_q;

  // lsb first: newest bit enters at the top
  assign byte_o = {bit_i, sh_q[BW-1:1]};
  assign done_o = shift_i && (cnt_q == CW'(BW-1));
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (shift_i) begin
      sh_q  <= byte_o;
      cnt_q <= done_o ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/srp_tx.sv
module srp_tx #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [BW-1:0] data_i,
  input  logic          shift_i,
  output logic          bit_o
);
  logic [BW-1:0] sh_q;

  assign bit_o = sh_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (clr_i)   sh_q <= '0;
    else if (load_i)  sh_q <= data_i;
    else if (shift_i) sh_q <= {1'b0, sh_q[BW-1:1]};
  end
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int WRAP_BITS = 4,
  parameter int WAIT_CYC = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sclk_i,
  input  logic          cs_ni,
  input  logic          sdi_i,
  input  logic          dir_i,
  output logic          sdo_o,
  output logic          sdo_oe_o,
  output logic          wait_o,
  output logic          rf_we_o,
  output logic          rf_re_o,
  output logic [AW-1:0] rf_addr_o,
  output logic [DW-1:0] rf_wdata_o,
  input  logic [DW-1:0] rf_rdata_i
);
  import srp_pkg::*;

  localparam int WCW = $clog2(WAIT_CYC + 1);
  localparam int BCW = $clog2(DW);

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a);
    logic [WRAP_BITS-1:0] lo;
    lo = a[WRAP_BITS-1:0] + 1'b1;
    return {a[AW-1:WRAP_BITS], lo};
  endfunction

  logic sclk_s, cs_s, sdi_s, dir_s, sclk_q;
  srp_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0011)) u_sync (
    .clk_i, .rst_ni,
    .d_i({dir_i, sdi_i, cs_ni, sclk_i}),
    .q_o({dir_s, sdi_s, cs_s, sclk_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sclk_q <= 1'b1;
    else         sclk_q <= sclk_s;
  end

  logic sclk_rise, sclk_fall;
  assign sclk_rise = sclk_s & ~sclk_q & ~cs_s;
  assign sclk_fall = ~sclk_s & sclk_q & ~cs_s;

  logic [DW-1:0]  rx_byte;
  logic           byte_done;
  logic [BCW-1:0] rx_cnt;
  srp_rx #(.BW(DW)) u_rx (
    .clk_i, .rst_ni,
    .clr_i(cs_s), .shift_i(sclk_rise), .bit_i(sdi_s),
    .byte_o(rx_byte), .done_o(byte_done), .cnt_o(rx_cnt)
  );

  phase_e        phase_q;
  logic          rd_q, re_d;
  logic [AW-1:0] addr_q;
  logic [WCW-1:0] wait_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_ADDR;
      rd_q       <= 1'b0;
      addr_q     <= '0;
      wait_cnt_q <= '0;
      rf_we_o    <= 1'b0;
      rf_re_o    <= 1'b0;
      rf_addr_o  <= '0;
      rf_wdata_o <= '0;
      re_d       <= 1'b0;
    end else begin
      rf_we_o <= 1'b0;
      rf_re_o <= 1'b0;
      re_d    <= rf_re_o & ~cs_s;
      if (wait_cnt_q != '0) wait_cnt_q <= wait_cnt_q - 1'b1;
      if (cs_s) begin
        phase_q    <= PH_ADDR;
        rd_q       <= 1'b0;
        wait_cnt_q <= '0;
      end else if (byte_done) begin
        if (phase_q == PH_ADDR) begin
          phase_q    <= PH_DATA;
          rd_q       <= dir_s;
          wait_cnt_q <= WCW'(WAIT_CYC);
          if (dir_s) begin
            // prefetch the first location at once
            rf_re_o   <= 1'b1;
            rf_addr_o <= rx_byte[AW-1:0];
            addr_q    <= step(rx_byte[AW-1:0]);
          end else begin
            addr_q <= rx_byte[AW-1:0];
          end
        end else begin
          rf_addr_o <= addr_q;
          addr_q    <= step(addr_q);
          if (rd_q) rf_re_o <= 1'b1;
          else begin
            rf_we_o    <= 1'b1;
            rf_wdata_o <= rx_byte;
          end
        end
      end
    end
  end

  logic tx_bit, tx_shift;
  assign tx_shift = sclk_fall & rd_q & (phase_q == PH_DATA) & (rx_cnt != '0);

  srp_tx #(.BW(DW)) u_tx (
    .clk_i, .rst_ni,
    .clr_i(cs_s), .load_i(re_d), .data_i(rf_rdata_i),
    .shift_i(tx_shift), .bit_o(tx_bit)
  );

  assign wait_o   = (wait_cnt_q != '0);
  assign sdo_oe_o = ~cs_s & rd_q & (phase_q == PH_DATA);
  assign sdo_o    = sdo_oe_o & tx_bit;
endmodule

// File: rtl/serial_reg_port_chk.sv
module serial_reg_port_chk #(
  parameter int AW = 8,
  parameter int WRAP_BITS = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_s,
  input logic          rd_q,
  input logic          in_data,
  input logic [AW-1:0] addr_q,
  input logic          sdo_o,
  input logic          sdo_oe_o,
  input logic          wait_o,
  input logic          rf_we_o,
  input logic          rf_re_o
);
  // R8
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |-> (!sdo_oe_o && !sdo_o));

  // R8
  write_no_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sdo_oe_o |-> rd_q);

  // R6
  wait_data_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_o |-> (in_data && !rf_we_o));

  // R2
  we_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |=> !rf_we_o);

  // R5
  read_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> !rd_q);

  // R3
  nibble_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_data && $past(in_data) && (addr_q != $past(addr_q))) |->
      (addr_q[AW-1:WRAP_BITS] == $past(addr_q[AW-1:WRAP_BITS]) &&
       addr_q[WRAP_BITS-1:0] == $past(addr_q[WRAP_BITS-1:0]) + 1'b1));

  // R1
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && rf_re_o));
endmodule

bind serial_reg_port serial_reg_port_chk #(.AW(AW), .WRAP_BITS(WRAP_BITS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .rd_q(rd_q),
  .in_data(phase_q == srp_pkg::PH_DATA), .addr_q(addr_q),
  .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o), .wait_o(wait_o),
  .rf_we_o(rf_we_o), .rf_re_o(rf_re_o)
);

// File: tb/serial_reg_port_test.sv
module serial_reg_port_test;
  localparam int HP = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b1, cs_n = 1'b1, sdi = 1'b0, dir = 1'b0;
  logic sdo, sdo_oe, wait_s, we, re;
  logic [7:0] addr, wdata, rdata;
  logic [7:0] mem [256];
  logic [7:0] exp_mem [256];
  int unsigned n_chk = 0, n_fail = 0, we_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  serial_reg_port uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdi_i(sdi),
    .dir_i(dir), .sdo_o(sdo), .sdo_oe_o(sdo_oe), .wait_o(wait_s),
    .rf_we_o(we), .rf_re_o(re), .rf_addr_o(addr), .rf_wdata_o(wdata),
    .rf_rdata_i(rdata)
  );

  initial for (int i = 0; i < 256; i++) begin
    mem[i] = 8'(i * 37 + 5);
    exp_mem[i] = 8'(i * 37 + 5);
  end

  always @(posedge clk) begin
    if (we) begin
      mem[addr] <= wdata;
      we_cnt <= we_cnt + 1;
    end
    if (re) rdata <= mem[addr];
  end

  function automatic logic [7:0] nxt(input logic [7:0] a);
    return {a[7:4], a[3:0] + 4'd1};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // returns at the cycle the last rising edge is driven
  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b0; sdi = tx[i];
      clks(HP);
      rx[i] = sdo;
      sclk = 1'b1;
      if (i < 7) clks(HP);
    end
  endtask

  task automatic open_frame(input bit rd, input logic [7:0] a);
    logic [7:0] dummy;
    cs_n = 1'b0; dir = rd;
    clks(HP);
    xfer(a, dummy);
    clks(5);
    chk(wait_s == 1'b1, "R6 wait after address", int'(wait_s), 1);
    clks(15);
    chk(wait_s == 1'b0, "R6 wait released", int'(wait_s), 0);
  endtask

  task automatic close_frame();
    clks(HP);
    cs_n = 1'b1;
    clks(HP);
  endtask

  task automatic write_burst(input logic [7:0] a0, input int n);
    logic [7:0] a, b, dummy;
    a = a0;
    open_frame(1'b0, a0);
    for (int k = 0; k < n; k++) begin
      b = 8'($urandom);
      exp_mem[a] = b;
      a = nxt(a);
      xfer(b, dummy);
      clks(5);
      chk(!wait_s, "R6 no wait between data", int'(wait_s), 0);
      chk(!sdo_oe && !sdo, "R8 quiet in write", int'({sdo_oe, sdo}), 0);
      clks(8);
    end
    close_frame();
  endtask

  task automatic read_burst(input logic [7:0] a0, input int n);
    logic [7:0] a, rx;
    int wc;
    a = a0;
    wc = we_cnt;
    open_frame(1'b1, a0);
    for (int k = 0; k < n; k++) begin
      xfer(8'($urandom), rx);
      chk(rx == exp_mem[a], "R4 read byte", int'(rx), int'(exp_mem[a]));
      a = nxt(a);
      clks(5);
      chk(!wait_s, "R6 no wait between data", int'(wait_s), 0);
      clks(8);
    end
    close_frame();
    chk(we_cnt == wc, "R5 no write in read", we_cnt, wc);
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    logic [7:0] dummy;
    int wc;
    void'($urandom(32'h5eed));
    clks(3);
    chk(!wait_s && !sdo_oe && !sdo && !we && !re, "R1 reset outputs",
        int'({wait_s, sdo_oe, sdo, we, re}), 0);
    rst_n = 1'b1;
    clks(4);
    chk(!wait_s && !sdo_oe && !sdo && we_cnt == 0, "R1 idle after reset",
        int'({wait_s, sdo_oe, sdo}), 0);

    // R2 R3: burst crossing the low nibble boundary
    write_burst(8'h3E, 4);
    mem_cmp("R2 write burst");
    chk(mem[8'h40] == exp_mem[8'h40], "R3 upper nibble kept", int'(mem[8'h40]),
        int'(exp_mem[8'h40]));
    chk(mem[8'h30] == exp_mem[8'h30], "R3 wrap to x0", int'(mem[8'h30]),
        int'(exp_mem[8'h30]));
    // R4 R3 R5: read back across the wrap with random SDI
    read_burst(8'h3E, 4);
    read_burst(8'hFF, 3);

    // R7: abort mid byte
    wc = we_cnt;
    cs_n = 1'b0; dir = 1'b0;
    clks(HP);
    xfer(8'h50, dummy);
    clks(20);
    for (int i = 0; i < 3; i++) begin
      sclk = 1'b0; sdi = 1'b1; clks(HP); sclk = 1'b1; clks(HP);
    end
    cs_n = 1'b1;
    clks(20);
    chk(we_cnt == wc, "R7 partial byte dropped", we_cnt, wc);
    chk(!sdo_oe && !sdo, "R8 quiet when deselected", int'({sdo_oe, sdo}), 0);
    write_burst(8'h51, 2);
    mem_cmp("R7 fresh frame after abort");

    // R9: direction changes after address byte
    wc = we_cnt;
    open_frame(1'b0, 8'h77);
    dir = 1'b1;
    xfer(8'hC3, dummy);
    exp_mem[8'h77] = 8'hC3;
    clks(8);
    chk(!sdo_oe, "R9 stays write", int'(sdo_oe), 0);
    close_frame();
    chk(we_cnt == wc + 1, "R9 write kept", we_cnt, wc + 1);
    mem_cmp("R9 data written");

    // random mix
    for (int t = 0; t < 24; t++) begin
      logic [7:0] a;
      int n;
      a = 8'($urandom);
      n = 1 + int'($urandom % 18);
      if ($urandom % 2) begin
        write_burst(a, n);
        mem_cmp("R2 random write");
      end else read_burst(a, n);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule